// File: doc/BRIEF.md
# Extended Dual Data Pointer Unit

This block holds the data pointer registers of an 8051-style core whose data address space has been widened to 23 bits. It keeps two 16-bit pointers, one of them active at a time, and one 23-bit extended pointer. Software reaches every byte through a small register bus. The core can also load a pointer as a whole word or increment it by one in a single cycle.

When the core issues an indirect access, the block forms the target address from either the active 16-bit pointer or the extended pointer. It then sends the access to one of three places. The first is the small on-chip RAM that sits at the bottom of the external-data space. The second is the external bus, which takes everything else. The third is an error flag, raised when the extended address is out of range or not yet enabled.

Register indices on the bus:

| Index | Register |
|-------|----------|
| 0 | pointer 0, low byte |
| 1 | pointer 0, high byte |
| 2 | pointer 1, low byte |
| 3 | pointer 1, high byte |
| 4 | extended pointer, low byte |
| 5 | extended pointer, middle byte |
| 6 | extended pointer, high byte |
| 7 | auxiliary control: bit 0 selects the active pointer, bit 1 disables the on-chip RAM |
| 8 | mode control: bit 0 enables extended addressing |

Bits of registers 7 and 8 that have no function read as 0. Any other index reads as 0x00 and a write to it has no effect.

Top module: `xdptr_unit`

## Requirements
- R1: After reset, both 16-bit pointers, the extended pointer, the select bit, the on-chip disable bit and the extended mode bit are all zero. The request, error and address outputs are also zero.
- R2: Byte writes at indices 0 to 6 update only the byte they address. Reads return the stored bytes at once, from combinational logic. The two 16-bit pointers hold independent values.
- R3: Bit 0 of index 7 selects the active 16-bit pointer (0 = pointer 0, 1 = pointer 1). Loads, increments and accesses that use a 16-bit pointer act on the active one. The select bit has no effect on the extended pointer.
- R4: Bit 7 of index 6 always reads 1. Writing it has no effect on the stored pointer value.
- R5: A word load (`wload_i`) replaces the whole target pointer in the next cycle. The target is the extended pointer when `ptr_ext_i`=1, which takes all 23 bits; otherwise it is the active 16-bit pointer, which takes bits 15:0. For the targeted pointer, a load wins over an increment, and an increment wins over a byte write made in the same cycle.
- R6: An increment (`inc_i`) adds one to the target pointer. A 16-bit pointer wraps from 0xFFFF to 0x0000. The extended pointer wraps from 0x7FFFFF to 0x000000.
- R7: An access whose address is below ONCHIP_BYTES (768) produces a one-cycle `xram_req_o` in the next cycle, with the address on `acc_addr_o`, provided the disable bit is clear.
- R8: While bit 1 of index 7 is set, no access raises `xram_req_o`. Every access that does not fail goes to the external bus.
- R9: Each access raises exactly one of `xram_req_o`, `bus_req_o` or `acc_err_o` for one cycle, in the next cycle. Addresses at or above 768, and all addresses above 0xFFFF, go to the bus with the full 23-bit address.
- R10: An extended-pointer access whose address is above 0x7EFFFF raises `acc_err_o` and no request.
- R11: An extended-pointer access above 0xFFFF raises `acc_err_o` while bit 0 of index 8 is clear. The same access is allowed once that bit is set.
- R12: An access through a 16-bit pointer always has bits 22:16 of `acc_addr_o` at zero and never raises `acc_err_o`. `acc_addr_o` holds its value between accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sfr_we_i | input | 1 | Byte write strobe |
| sfr_idx_i | input | 4 | Register index |
| sfr_wdata_i | input | 8 | Byte write data |
| sfr_rdata_o | output | 8 | Byte read data for the indexed register |
| ptr_ext_i | input | 1 | Load, increment and access use the extended pointer (1) or the active 16-bit pointer (0) |
| wload_i | input | 1 | Whole-word load of the target pointer |
| wload_data_i | input | 23 | Word load value |
| inc_i | input | 1 | Increment the target pointer |
| acc_req_i | input | 1 | Indirect access request |
| xram_req_o | output | 1 | One-cycle strobe to on-chip RAM |
| bus_req_o | output | 1 | One-cycle strobe to external bus |
| acc_err_o | output | 1 | One-cycle access error |
| acc_addr_o | output | 23 | Address of the last access |

## Verification
The bench builds the block with its default parameters. These are a 768-byte on-chip region, a 23-bit extended pointer and an upper limit of 0x7EFFFF. With these values every routing edge can be reached with a directed load: 0x2FF against 0x300, 0xFFFF against 0x10000, 0x7EFFFF against 0x7F0000, and the 0x7FFFFF wrap. Random loads are biased toward small addresses and toward the area near the limit, so the on-chip path and the error path both occur often under random control-bit changes.

// File: rtl/xdptr_pkg.sv
package xdptr_pkg;
  localparam int unsigned IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    IDX_P0_LO = 4'd0,
    IDX_P0_HI = 4'd1,
    IDX_P1_LO = 4'd2,
    IDX_P1_HI = 4'd3,
    IDX_E_LO  = 4'd4,
    IDX_E_MID = 4'd5,
    IDX_E_HI  = 4'd6,
    IDX_AUX   = 4'd7,
    IDX_MODE  = 4'd8
  } sfr_idx_e;
endpackage

// File: rtl/xdptr_bank.sv
module xdptr_bank #(
  parameter int unsigned PTR_W = 16,
  parameter int unsigned N_PTR = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_PTR-1:0]            we_lo_i,
  input  logic [N_PTR-1:0]            we_hi_i,
  input  logic [7:0]                  wdata_i,
  input  logic [N_PTR-1:0]            load_i,
  input  logic [N_PTR-1:0]            inc_i,
  input  logic [PTR_W-1:0]            load_data_i,
  output logic [N_PTR-1:0][PTR_W-1:0] ptr_o
);
  localparam int unsigned HI_W = PTR_W - 8;

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    logic [PTR_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (load_i[g]) begin
        q <= load_data_i;
      end else if (inc_i[g]) begin
        q <= q + PTR_W'(1);
      end else begin
        if (we_lo_i[g]) q[7:0]       <= wdata_i;
        if (we_hi_i[g]) q[PTR_W-1:8] <= wdata_i[HI_W-1:0];
      end
    end
    assign ptr_o[g] = q;
  end
endmodule

// File: rtl/xdptr_ext.sv
module xdptr_ext #(
  parameter int unsigned EXT_W = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       we_i,
  input  logic [7:0]       wdata_i,
  input  logic             load_i,
  input  logic             inc_i,
  input  logic [EXT_W-1:0] load_data_i,
  output logic [EXT_W-1:0] ptr_o
);
  localparam int unsigned TOP_W = EXT_W - 16;

  logic [EXT_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (load_i) begin
      q <= load_data_i;
    end else if (inc_i) begin
      q <= q + EXT_W'(1);
    end else begin
      if (we_i[0]) q[7:0]        <= wdata_i;
      if (we_i[1]) q[15:8]       <= wdata_i;
      if (we_i[2]) q[EXT_W-1:16] <= wdata_i[TOP_W-1:0];
    end
  end

  assign ptr_o = q;
endmodule

// File: rtl/xdptr_route.sv
module xdptr_route #(
  parameter int unsigned     PTR_W        = 16,
  parameter int unsigned     EXT_W        = 23,
  parameter int unsigned     ONCHIP_BYTES = 768,
  parameter logic [EXT_W-1:0] HIGH_LIMIT  = 23'h7E_FFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             use_ext_i,
  input  logic [PTR_W-1:0] dptr_i,
  input  logic [EXT_W-1:0] eptr_i,
  input  logic             xram_off_i,
  input  logic             ext_mode_i,
  output logic             xram_req_o,
  output logic             bus_req_o,
  output logic             err_o,
  output logic [EXT_W-1:0] addr_o
);
  logic [EXT_W-1:0] addr_c;
  logic             above_64k, err_c, onchip_c;

  assign addr_c    = use_ext_i ? eptr_i : EXT_W'(dptr_i);
  assign above_64k = |addr_c[EXT_W-1:PTR_W];
  assign err_c     = use_ext_i && ((addr_c > HIGH_LIMIT) || (above_64k && !ext_mode_i));
  assign onchip_c  = !above_64k && (addr_c < EXT_W'(ONCHIP_BYTES)) && !xram_off_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xram_req_o <= 1'b0;
      bus_req_o  <= 1'b0;
      err_o      <= 1'b0;
      addr_o     <= '0;
    end else begin
      xram_req_o <= req_i && !err_c && onchip_c;
      bus_req_o  <= req_i && !err_c && !onchip_c;
      err_o      <= req_i && err_c;
      if (req_i) addr_o <= addr_c;
    end
  end
endmodule

// File: rtl/xdptr_unit.sv
module xdptr_unit
  import xdptr_pkg::*;
#(
  parameter int unsigned      PTR_W        = 16,
  parameter int unsigned      EXT_W        = 23,
  parameter int unsigned      ONCHIP_BYTES = 768,
  parameter logic [EXT_W-1:0] HIGH_LIMIT   = 23'h7E_FFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sfr_we_i,
  input  logic [IDX_W-1:0] sfr_idx_i,
  input  logic [7:0]       sfr_wdata_i,
  output logic [7:0]       sfr_rdata_o,
  input  logic             ptr_ext_i,
  input  logic             wload_i,
  input  logic [EXT_W-1:0] wload_data_i,
  input  logic             inc_i,
  input  logic             acc_req_i,
  output logic             xram_req_o,
  output logic             bus_req_o,
  output logic             acc_err_o,
  output logic [EXT_W-1:0] acc_addr_o
);
  localparam int unsigned N_PTR = 2;
  localparam int unsigned TOP_W = EXT_W - 16;

  logic                        sel_q, xram_off_q, ext_mode_q;
  logic [N_PTR-1:0][PTR_W-1:0] dptr;
  logic [EXT_W-1:0]            eptr_q;
  logic [N_PTR-1:0]            we_lo, we_hi, d_load, d_inc;
  logic [2:0]                  e_we;
  logic [PTR_W-1:0]            dptr_act;

  always_comb begin
    we_lo = '0;
    we_hi = '0;
    e_we  = '0;
    if (sfr_we_i) begin
      unique case (sfr_idx_i)
        IDX_P0_LO: we_lo[0] = 1'b1;
        IDX_P0_HI: we_hi[0] = 1'b1;
        IDX_P1_LO: we_lo[1] = 1'b1;
        IDX_P1_HI: we_hi[1] = 1'b1;
        IDX_E_LO:  e_we[0]  = 1'b1;
        IDX_E_MID: e_we[1]  = 1'b1;
        IDX_E_HI:  e_we[2]  = 1'b1;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < N_PTR; g++) begin : g_ctl
    assign d_load[g] = wload_i && !ptr_ext_i && (sel_q == g[0]);
    assign d_inc[g]  = inc_i   && !ptr_ext_i && (sel_q == g[0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q      <= 1'b0;
      xram_off_q <= 1'b0;
      ext_mode_q <= 1'b0;
    end else if (sfr_we_i) begin
      if (sfr_idx_i == IDX_AUX) begin
        sel_q      <= sfr_wdata_i[0];
        xram_off_q <= sfr_wdata_i[1];
      end
      if (sfr_idx_i == IDX_MODE) ext_mode_q <= sfr_wdata_i[0];
    end
  end

  xdptr_bank #(.PTR_W(PTR_W), .N_PTR(N_PTR)) bank_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_lo_i     (we_lo),
    .we_hi_i     (we_hi),
    .wdata_i     (sfr_wdata_i),
    .load_i      (d_load),
    .inc_i       (d_inc),
    .load_data_i (wload_data_i[PTR_W-1:0]),
    .ptr_o       (dptr)
  );

  xdptr_ext #(.EXT_W(EXT_W)) ext_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (e_we),
    .wdata_i     (sfr_wdata_i),
    .load_i      (wload_i && ptr_ext_i),
    .inc_i       (inc_i && ptr_ext_i),
    .load_data_i (wload_data_i),
    .ptr_o       (eptr_q)
  );

  assign dptr_act = dptr[sel_q];

  xdptr_route #(
    .PTR_W(PTR_W), .EXT_W(EXT_W), .ONCHIP_BYTES(ONCHIP_BYTES), .HIGH_LIMIT(HIGH_LIMIT)
  ) route_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (acc_req_i),
    .use_ext_i  (ptr_ext_i),
    .dptr_i     (dptr_act),
    .eptr_i     (eptr_q),
    .xram_off_i (xram_off_q),
    .ext_mode_i (ext_mode_q),
    .xram_req_o (xram_req_o),
    .bus_req_o  (bus_req_o),
    .err_o      (acc_err_o),
    .addr_o     (acc_addr_o)
  );

  always_comb begin
    sfr_rdata_o = 8'h00;
    unique case (sfr_idx_i)
      IDX_P0_LO: sfr_rdata_o = dptr[0][7:0];
      IDX_P0_HI: sfr_rdata_o = dptr[0][PTR_W-1:8];
      IDX_P1_LO: sfr_rdata_o = dptr[1][7:0];
      IDX_P1_HI: sfr_rdata_o = dptr[1][PTR_W-1:8];
      IDX_E_LO:  sfr_rdata_o = eptr_q[7:0];
      IDX_E_MID: sfr_rdata_o = eptr_q[15:8];
      IDX_E_HI:  sfr_rdata_o = {{(8-TOP_W){1'b1}}, eptr_q[EXT_W-1:16]};
      IDX_AUX:   sfr_rdata_o = {6'b0, xram_off_q, sel_q};
      IDX_MODE:  sfr_rdata_o = {7'b0, ext_mode_q};
      default: ;
    endcase
  end
endmodule

// File: rtl/xdptr_chk.sv
module xdptr_chk #(
  parameter int unsigned      EXT_W        = 23,
  parameter int unsigned      ONCHIP_BYTES = 768,
  parameter logic [EXT_W-1:0] HIGH_LIMIT   = 23'h7E_FFFF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       sfr_idx_i,
  input logic [7:0]       sfr_rdata_o,
  input logic             ptr_ext_i,
  input logic             wload_i,
  input logic             inc_i,
  input logic             acc_req_i,
  input logic             xram_req_o,
  input logic             bus_req_o,
  input logic             acc_err_o,
  input logic [EXT_W-1:0] acc_addr_o,
  input logic [EXT_W-1:0] eptr_q,
  input logic             xram_off_q
);
  assert_one_target_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({xram_req_o, bus_req_o, acc_err_o}));

  assert_strobe_needs_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_req_i |=> !(xram_req_o || bus_req_o || acc_err_o));

  assert_xram_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xram_req_o |-> (acc_addr_o < EXT_W'(ONCHIP_BYTES)));

  assert_xram_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xram_off_q && acc_req_i |=> !xram_req_o);

  assert_limit_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_req_i && ptr_ext_i && (eptr_q > HIGH_LIMIT) |=> acc_err_o);

  assert_eptr_inc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && ptr_ext_i && !wload_i |=> eptr_q == $past(eptr_q) + EXT_W'(1));

  assert_top_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_idx_i == 4'd6) |-> sfr_rdata_o[7]);
endmodule

bind xdptr_unit xdptr_chk #(
  .EXT_W(EXT_W), .ONCHIP_BYTES(ONCHIP_BYTES), .HIGH_LIMIT(HIGH_LIMIT)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sfr_idx_i   (sfr_idx_i),
  .sfr_rdata_o (sfr_rdata_o),
  .ptr_ext_i   (ptr_ext_i),
  .wload_i     (wload_i),
  .inc_i       (inc_i),
  .acc_req_i   (acc_req_i),
  .xram_req_o  (xram_req_o),
  .bus_req_o   (bus_req_o),
  .acc_err_o   (acc_err_o),
  .acc_addr_o  (acc_addr_o),
  .eptr_q      (eptr_q),
  .xram_off_q  (xram_off_q)
);

// File: tb/xdptr_unit_tb.sv
module xdptr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  idx = '0;
  logic [7:0]  wd = '0;
  logic [7:0]  rd;
  logic        ext = 1'b0, ld = 1'b0, inc = 1'b0, req = 1'b0;
  logic [22:0] ldd = '0;
  logic        xr, br, er;
  logic [22:0] ad;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference state
  logic [15:0] m_p0, m_p1;
  logic [22:0] m_e;
  logic        m_sel, m_off, m_mode;
  logic        x_xr, x_br, x_er;
  logic [22:0] x_ad;

  always #5 clk = ~clk;

  xdptr_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sfr_we_i(we), .sfr_idx_i(idx), .sfr_wdata_i(wd),
    .sfr_rdata_o(rd), .ptr_ext_i(ext), .wload_i(ld), .wload_data_i(ldd), .inc_i(inc),
    .acc_req_i(req), .xram_req_o(xr), .bus_req_o(br), .acc_err_o(er), .acc_addr_o(ad)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [3:0] i);
    case (i)
      4'd0: return m_p0[7:0];
      4'd1: return m_p0[15:8];
      4'd2: return m_p1[7:0];
      4'd3: return m_p1[15:8];
      4'd4: return m_e[7:0];
      4'd5: return m_e[15:8];
      4'd6: return {1'b1, m_e[22:16]};
      4'd7: return {6'b0, m_off, m_sel};
      4'd8: return {7'b0, m_mode};
      default: return 8'h00;
    endcase
  endfunction

  // one cycle: inputs set at negedge, outputs compared at the next negedge
  task automatic cyc(input logic w, input logic [3:0] i, input logic [7:0] d,
                     input logic e, input logic l, input logic [22:0] ldv,
                     input logic n, input logic r, input string tag);
    logic [22:0] a;
    logic [15:0] np0, np1;
    logic [22:0] ne;
    logic hi64;
    we = w; idx = i; wd = d; ext = e; ld = l; ldd = ldv; inc = n; req = r;
    a = e ? m_e : {7'b0, (m_sel ? m_p1 : m_p0)};
    hi64 = |a[22:16];
    x_xr = 1'b0; x_br = 1'b0; x_er = 1'b0;
    if (r) begin
      x_ad = a;
      if (e && (a > 23'h7EFFFF || (hi64 && !m_mode))) x_er = 1'b1;
      else if (!hi64 && a < 23'd768 && !m_off) x_xr = 1'b1;
      else x_br = 1'b1;
    end
    np0 = m_p0; np1 = m_p1; ne = m_e;
    if (w) begin
      case (i)
        4'd0: np0[7:0] = d;
        4'd1: np0[15:8] = d;
        4'd2: np1[7:0] = d;
        4'd3: np1[15:8] = d;
        4'd4: ne[7:0] = d;
        4'd5: ne[15:8] = d;
        4'd6: ne[22:16] = d[6:0];
        default: ;
      endcase
    end
    if (l || n) begin
      if (e) ne = l ? ldv : m_e + 23'd1;
      else if (m_sel) np1 = l ? ldv[15:0] : m_p1 + 16'd1;
      else np0 = l ? ldv[15:0] : m_p0 + 16'd1;
    end
    if (w && i == 4'd7) begin m_sel = d[0]; m_off = d[1]; end
    if (w && i == 4'd8) m_mode = d[0];
    m_p0 = np0; m_p1 = np1; m_e = ne;
    @(negedge clk);
    we = 1'b0; ld = 1'b0; inc = 1'b0; req = 1'b0;
    chk({tag, " xram_req"}, 32'(xr), 32'(x_xr));
    chk({tag, " bus_req"}, 32'(br), 32'(x_br));
    chk({tag, " err"}, 32'(er), 32'(x_er));
    chk({tag, " addr"}, 32'(ad), 32'(x_ad));
  endtask

  task automatic rd_all(input string tag);
    for (int k = 0; k < 10; k++) begin
      idx = 4'(k);
      #1;
      chk($sformatf("%s read idx %0d", tag, k), 32'(rd), 32'(m_read(4'(k))));
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] d, input string tag);
    cyc(1'b1, i, d, 1'b0, 1'b0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic acc(input logic e, input string tag);
    cyc(1'b0, '0, '0, e, 1'b0, '0, 1'b0, 1'b1, tag);
  endtask

  task automatic load(input logic e, input logic [22:0] v, input string tag);
    cyc(1'b0, '0, '0, e, 1'b1, v, 1'b0, 1'b0, tag);
  endtask

  function automatic logic [22:0] pick_addr();
    case ($urandom_range(0, 4))
      0: return 23'($urandom_range(0, 1023));
      1: return 23'($urandom_range(0, 65535));
      2: return 23'h7E_FFF0 + 23'($urandom_range(0, 31));
      3: return 23'h00_FFF8 + 23'($urandom_range(0, 15));
      default: return 23'($urandom);
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_p0 = '0; m_p1 = '0; m_e = '0; m_sel = 0; m_off = 0; m_mode = 0; x_ad = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 outputs", {29'b0, xr, br, er}, 32'd0);
    chk("R1 addr", 32'(ad), 32'd0);
    rd_all("R1");

    // R2 byte access, independent pointers
    wr(4'd0, 8'h12, "R2"); wr(4'd1, 8'h34, "R2");
    wr(4'd2, 8'hAB, "R2"); wr(4'd3, 8'hCD, "R2");
    wr(4'd4, 8'h01, "R2"); wr(4'd5, 8'h02, "R2");
    rd_all("R2");

    // R4 top bit reads one, write ignored
    wr(4'd6, 8'hFF, "R4");
    rd_all("R4");
    load(1'b1, 23'h00_0000, "R4 clear");
    wr(4'd6, 8'h80, "R4");
    idx = 4'd6; #1; chk("R4 e_hi after 0x80", 32'(rd), 32'h80);

    // R3 select bit chooses active pointer; extended untouched
    load(1'b0, 23'h00_0100, "R3 load p0");
    wr(4'd7, 8'h01, "R3 sel");
    load(1'b0, 23'h00_0200, "R3 load p1");
    acc(1'b0, "R3 acc p1");
    chk("R3 p1 addr", 32'(ad), 32'h200);
    rd_all("R3");

    // R5 priority: load over inc over byte write
    cyc(1'b1, 4'd2, 8'h55, 1'b0, 1'b1, 23'h00_1234, 1'b1, 1'b0, "R5 ld>inc>wr");
    rd_all("R5");
    cyc(1'b1, 4'd2, 8'h55, 1'b0, 1'b0, '0, 1'b1, 1'b0, "R5 inc>wr");
    rd_all("R5");

    // R6 wraps
    load(1'b0, 23'h00_FFFF, "R6"); cyc(0, 0, 0, 1'b0, 0, '0, 1'b1, 0, "R6 inc16");
    rd_all("R6 16");
    load(1'b1, 23'h7F_FFFF, "R6"); cyc(0, 0, 0, 1'b1, 0, '0, 1'b1, 0, "R6 inc23");
    rd_all("R6 23");

    // R7/R9 on-chip boundary
    wr(4'd7, 8'h00, "R7 sel0");
    load(1'b0, 23'h2FF, "R7"); acc(1'b0, "R7 0x2FF onchip");
    load(1'b0, 23'h300, "R9"); acc(1'b0, "R9 0x300 bus");
    load(1'b1, 23'h0000_10, "R7"); acc(1'b1, "R7 ext low onchip");
    // R8 disable
    wr(4'd7, 8'h02, "R8 off");
    load(1'b0, 23'h010, "R8"); acc(1'b0, "R8 forced bus");
    wr(4'd7, 8'h00, "R8 on");
    // R11 mode bit
    load(1'b1, 23'h01_0000, "R11"); acc(1'b1, "R11 high no mode");
    wr(4'd8, 8'h01, "R11 mode");
    acc(1'b1, "R11 high with mode");
    // R10 limit
    load(1'b1, 23'h7E_FFFF, "R10"); acc(1'b1, "R10 at limit");
    load(1'b1, 23'h7F_0000, "R10"); acc(1'b1, "R10 over limit");
    // R12 addr held, 16-bit access top bits zero
    cyc(0, 0, 0, 0, 0, '0, 0, 0, "R12 hold");
    load(1'b0, 23'h7F_FFFF, "R12"); acc(1'b0, "R12 dptr top zero");

    // random mix
    for (int t = 0; t < 3000; t++) begin
      logic w, e, l, n, r;
      logic [3:0] i;
      w = ($urandom_range(0, 3) == 0);
      i = 4'($urandom_range(0, 9));
      e = $urandom_range(0, 1);
      l = ($urandom_range(0, 3) == 0);
      n = ($urandom_range(0, 4) == 0);
      r = ($urandom_range(0, 1) == 1);
      cyc(w, i, 8'($urandom), e, l, pick_addr(), n, r, "R9 random");
      if (t % 50 == 0) rd_all("R2 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule